// File: doc/BRIEF.md
# Scoreboard Issue Gate

This block decides, once per cycle, whether the single decoded instruction at the head of an in-order issue stage may go to its functional unit. It keeps one pending-write flag per general-purpose register. A set flag means that an instruction already issued will still write that register. A clear flag means the register file holds the current value. The units finish in any order, and each finished result names its destination register on one of the completion ports. That clears the register's flag.

The gate holds no instructions. When it withholds the grant, the front end keeps the same instruction on the inputs, so every younger instruction waits behind it and issue stays in program order. The gate blocks an instruction for three reasons: a source register is still pending (read-after-write), the destination register is still pending (write-after-write), or the target unit is busy. Each cycle the gate reports which reason applied as a 2-bit code. Completions that arrive in the same cycle as the check are visible to it, so a result that lands in the cycle an instruction waits for it lets that instruction go at once.

Top module: `issue_gate`

## Requirements
- R1: After reset every bit of `pending_vec` is 0. Bit i of `pending_vec` is 1 exactly when register i has an outstanding write.
- R2: When `in_valid` is 1 and the pending bit of `in_rs` or of `in_rt` is set, `issue_grant` is 0 and `stall_code` is 2'b01 (RAW).
- R3: When `in_valid` is 1, the destination `in_rd` is pending and neither source is pending, `issue_grant` is 0 and `stall_code` is 2'b10 (WAW).
- R4: When `in_valid` is 1 and there is no hazard, `issue_grant` is 1 and `stall_code` is 2'b00. From the next cycle the bit for `in_rd` in `pending_vec` is 1.
- R5: When `in_valid` is 1, there is no register hazard and `unit_busy[in_unit]` is 1, `issue_grant` is 0 and `stall_code` is 2'b11 (unit busy).
- R6: When more than one cause applies, the code follows the priority RAW (01) over WAW (10) over unit busy (11).
- R7: When `in_valid` is 0, `issue_grant` is 0 and `stall_code` is 2'b00, and no pending bit becomes set.
- R8: A completion on either port (`cmp_valid[p]`, register `cmp_reg[p*5 +: 5]`) clears that register's pending bit from the next cycle on, unless an instruction is granted to the same register in that cycle.
- R9: A completion also acts on the hazard check in the same cycle: a register being cleared counts as not pending.
- R10: Register 0 is never pending. An instruction granted with `in_rd` = 0 sets no bit.
- R11: When both ports clear the same register in one cycle, the result is the same as a single clear. A grant and a completion to the same register in one cycle leave its bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction present at issue |
| in_rd | input | 5 | Destination register |
| in_rs | input | 5 | First source register |
| in_rt | input | 5 | Second source register |
| in_unit | input | 2 | Target functional-unit class |
| unit_busy | input | 4 | Busy flag per unit class |
| cmp_valid | input | 2 | Completion strobe per port |
| cmp_reg | input | 10 | Completed register per port, port p at bits p*5 +: 5 |
| issue_grant | output | 1 | Instruction dispatched this cycle |
| stall_code | output | 2 | 00 none, 01 RAW, 10 WAW, 11 unit busy |
| pending_vec | output | 32 | Pending-write flags |

## Verification
The bound checker watches five things on every cycle: a granted destination shows as pending in the next cycle, a completed register shows as clear, register 0 stays clear, a busy unit never receives a grant, and the stall code agrees with the grant. It also checks that at most one flag is added per cycle. The bench's scenarios are needed for the rest: the code that wins when several causes apply, a completion letting a waiting instruction go in the same cycle, two clears to one register, and a grant racing a clear to the same register.

// File: rtl/isg_pkg.sv
package isg_pkg;

    typedef enum logic [1:0] {
        STALL_NONE = 2'd0,
        STALL_RAW  = 2'd1,
        STALL_WAW  = 2'd2,
        STALL_UNIT = 2'd3
    } stall_e;

endpackage

// File: rtl/isg_clear_decode.sv
module isg_clear_decode #(
    parameter int REG_W   = 5,
    parameter int NUM_CMP = 2,
    localparam int NUM_REGS = 1 << REG_W
) (
    input  logic [NUM_CMP-1:0]       cmp_valid,
    input  logic [NUM_CMP*REG_W-1:0] cmp_reg,
    output logic [NUM_REGS-1:0]      clr_mask
);

    logic [NUM_REGS-1:0] port_mask [NUM_CMP];

    // One one-hot mask per port; identical registers merge by OR.
    for (genvar p = 0; p < NUM_CMP; p++) begin : g_port
        always_comb begin
            port_mask[p] = '0;
            if (cmp_valid[p]) begin
                port_mask[p][cmp_reg[p*REG_W +: REG_W]] = 1'b1;
            end
        end
    end

    always_comb begin
        clr_mask = '0;
        for (int p = 0; p < NUM_CMP; p++) begin
            clr_mask = clr_mask | port_mask[p];
        end
    end

endmodule

// File: rtl/isg_pending_file.sv
module isg_pending_file #(
    parameter int REG_W = 5,
    localparam int NUM_REGS = 1 << REG_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [REG_W-1:0]    set_idx,
    input  logic [NUM_REGS-1:0] clr_mask,
    output logic [NUM_REGS-1:0] pend_q,
    output logic [NUM_REGS-1:0] pend_eff
);

    logic [NUM_REGS-1:0] set_mask;
    logic [NUM_REGS-1:0] pend_d;

    // Register 0 never gets a flag.
    always_comb begin
        set_mask = '0;
        if (set_en && (set_idx != '0)) begin
            set_mask[set_idx] = 1'b1;
        end
    end

    // Completions are seen by the check in the same cycle.
    assign pend_eff = pend_q & ~clr_mask;
    // A new issue wins over a clear to the same register.
    assign pend_d   = pend_eff | set_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end

endmodule

// File: rtl/isg_hazard_detect.sv
module isg_hazard_detect
    import isg_pkg::*;
#(
    parameter int REG_W  = 5,
    parameter int UNIT_W = 2,
    localparam int NUM_REGS  = 1 << REG_W,
    localparam int NUM_UNITS = 1 << UNIT_W
) (
    input  logic [NUM_REGS-1:0]  pend_eff,
    input  logic                 in_valid,
    input  logic [REG_W-1:0]     in_rd,
    input  logic [REG_W-1:0]     in_rs,
    input  logic [REG_W-1:0]     in_rt,
    input  logic [UNIT_W-1:0]    in_unit,
    input  logic [NUM_UNITS-1:0] unit_busy,
    output logic                 grant,
    output stall_e               cause
);

    logic raw_hit;
    logic waw_hit;
    logic unit_hit;

    assign raw_hit  = pend_eff[in_rs] | pend_eff[in_rt];
    assign waw_hit  = pend_eff[in_rd];
    assign unit_hit = unit_busy[in_unit];

    always_comb begin
        cause = STALL_NONE;
        if (in_valid) begin
            if (raw_hit) begin
                cause = STALL_RAW;
            end else if (waw_hit) begin
                cause = STALL_WAW;
            end else if (unit_hit) begin
                cause = STALL_UNIT;
            end
        end
    end

    assign grant = in_valid && (cause == STALL_NONE);

endmodule

// File: rtl/issue_gate.sv
module issue_gate
    import isg_pkg::*;
#(
    parameter int REG_W   = 5,
    parameter int UNIT_W  = 2,
    parameter int NUM_CMP = 2,
    localparam int NUM_REGS  = 1 << REG_W,
    localparam int NUM_UNITS = 1 << UNIT_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [REG_W-1:0]         in_rd,
    input  logic [REG_W-1:0]         in_rs,
    input  logic [REG_W-1:0]         in_rt,
    input  logic [UNIT_W-1:0]        in_unit,
    input  logic [NUM_UNITS-1:0]     unit_busy,
    input  logic [NUM_CMP-1:0]       cmp_valid,
    input  logic [NUM_CMP*REG_W-1:0] cmp_reg,
    output logic                     issue_grant,
    output logic [1:0]               stall_code,
    output logic [NUM_REGS-1:0]      pending_vec
);

    logic [NUM_REGS-1:0] clr_mask;
    logic [NUM_REGS-1:0] pend_eff;
    logic                grant;
    stall_e              cause;

    isg_clear_decode #(.REG_W(REG_W), .NUM_CMP(NUM_CMP)) u_clr (
        .cmp_valid (cmp_valid),
        .cmp_reg   (cmp_reg),
        .clr_mask  (clr_mask)
    );

    isg_hazard_detect #(.REG_W(REG_W), .UNIT_W(UNIT_W)) u_haz (
        .pend_eff  (pend_eff),
        .in_valid  (in_valid),
        .in_rd     (in_rd),
        .in_rs     (in_rs),
        .in_rt     (in_rt),
        .in_unit   (in_unit),
        .unit_busy (unit_busy),
        .grant     (grant),
        .cause     (cause)
    );

    isg_pending_file #(.REG_W(REG_W)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (grant),
        .set_idx  (in_rd),
        .clr_mask (clr_mask),
        .pend_q   (pending_vec),
        .pend_eff (pend_eff)
    );

    assign issue_grant = grant;
    assign stall_code  = cause;

endmodule

// File: rtl/isg_checker.sv
module isg_checker #(
    parameter int REG_W   = 5,
    parameter int UNIT_W  = 2,
    parameter int NUM_CMP = 2,
    localparam int NUM_REGS  = 1 << REG_W,
    localparam int NUM_UNITS = 1 << UNIT_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic [REG_W-1:0]         in_rd,
    input logic [UNIT_W-1:0]        in_unit,
    input logic [NUM_UNITS-1:0]     unit_busy,
    input logic [NUM_CMP-1:0]       cmp_valid,
    input logic [NUM_CMP*REG_W-1:0] cmp_reg,
    input logic                     issue_grant,
    input logic [1:0]               stall_code,
    input logic [NUM_REGS-1:0]      pending_vec
);

    AST_GRANT_SETS_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_grant && in_rd != '0) |=> pending_vec[$past(in_rd)]); // R4

    AST_REG0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_vec[0]); // R10

    AST_BUSY_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && unit_busy[in_unit]) |-> !issue_grant); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!issue_grant && stall_code == 2'b00)); // R7

    AST_CODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !issue_grant) |-> (stall_code != 2'b00)); // R2

    AST_ONE_SET_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pending_vec) <= $countones($past(pending_vec)) + 1); // R1

    for (genvar p = 0; p < NUM_CMP; p++) begin : g_cmp
        AST_CMP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_valid[p] && !(issue_grant && in_rd == cmp_reg[p*REG_W +: REG_W]))
            |=> !pending_vec[$past(cmp_reg[p*REG_W +: REG_W])]); // R8
    end

endmodule

bind issue_gate isg_checker #(.REG_W(REG_W), .UNIT_W(UNIT_W), .NUM_CMP(NUM_CMP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_rd       (in_rd),
    .in_unit     (in_unit),
    .unit_busy   (unit_busy),
    .cmp_valid   (cmp_valid),
    .cmp_reg     (cmp_reg),
    .issue_grant (issue_grant),
    .stall_code  (stall_code),
    .pending_vec (pending_vec)
);

// File: tb/issue_gate_tb_top.sv
module issue_gate_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  in_rd = '0, in_rs = '0, in_rt = '0;
    logic [1:0]  in_unit = '0;
    logic [3:0]  unit_busy = '0;
    logic [1:0]  cmp_valid = '0;
    logic [9:0]  cmp_reg = '0;
    logic        issue_grant;
    logic [1:0]  stall_code;
    logic [31:0] pending_vec;

    always #(CLK_PERIOD/2) clk = ~clk;

    issue_gate dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_rd(in_rd),
        .in_rs(in_rs), .in_rt(in_rt), .in_unit(in_unit), .unit_busy(unit_busy),
        .cmp_valid(cmp_valid), .cmp_reg(cmp_reg), .issue_grant(issue_grant),
        .stall_code(stall_code), .pending_vec(pending_vec)
    );

    typedef struct {
        logic        grant;
        logic [1:0]  code;
        logic [31:0] pend;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] model_pend = '0;
    int          n_checks = 0;
    int          n_fails = 0;
    bit          finished = 0;

    task automatic drive(input logic v, input logic [4:0] rd, input logic [4:0] rs,
                         input logic [4:0] rt, input logic [1:0] unit,
                         input logic [3:0] busy, input logic cv0, input logic [4:0] cr0,
                         input logic cv1, input logic [4:0] cr1, input string tag);
        logic [31:0] clr, eff;
        logic        raw, waw, st, g;
        logic [1:0]  code;
        exp_t        e;
        @(negedge clk);
        in_valid = v; in_rd = rd; in_rs = rs; in_rt = rt; in_unit = unit;
        unit_busy = busy; cmp_valid = {cv1, cv0}; cmp_reg = {cr1, cr0};
        clr = '0;
        if (cv0) clr[cr0] = 1'b1;
        if (cv1) clr[cr1] = 1'b1;
        eff  = model_pend & ~clr;
        raw  = eff[rs] | eff[rt];
        waw  = eff[rd];
        st   = busy[unit];
        g    = v && !raw && !waw && !st;
        code = (!v || g) ? 2'b00 : raw ? 2'b01 : waw ? 2'b10 : 2'b11;
        e.grant = g; e.code = code; e.pend = model_pend; e.tag = tag;
        exp_q.push_back(e);
        model_pend = eff;
        if (g && rd != 5'd0) model_pend[rd] = 1'b1;
    endtask

    task automatic idle(input string tag);
        drive(1'b0, 5'd0, 5'd0, 5'd0, 2'd0, 4'h0, 1'b0, 5'd0, 1'b0, 5'd0, tag);
    endtask

    // Monitor: compare a quarter period after each input change.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (issue_grant !== e.grant || stall_code !== e.code || pending_vec !== e.pend) begin
                    n_fails++;
                    $display("FAIL %s: grant=%0b code=%0d pend=%h expected grant=%0b code=%0d pend=%h",
                             e.tag, issue_grant, stall_code, pending_vec, e.grant, e.code, e.pend);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R1 reset clear, R7 idle");
        drive(1, 5'd3, 5'd1, 5'd2, 2'd0, 4'h0, 0, 5'd0, 0, 5'd0, "R4 grant r3");
        drive(1, 5'd5, 5'd3, 5'd4, 2'd0, 4'h0, 0, 5'd0, 0, 5'd0, "R2 raw on rs");
        drive(1, 5'd5, 5'd4, 5'd3, 2'd0, 4'h0, 0, 5'd0, 0, 5'd0, "R2 raw on rt");
        drive(1, 5'd3, 5'd6, 5'd7, 2'd0, 4'h0, 0, 5'd0, 0, 5'd0, "R3 waw r3");
        drive(1, 5'd8, 5'd1, 5'd2, 2'd1, 4'h2, 0, 5'd0, 0, 5'd0, "R5 unit busy");
        drive(1, 5'd3, 5'd3, 5'd1, 2'd1, 4'h2, 0, 5'd0, 0, 5'd0, "R6 raw over waw/unit");
        drive(1, 5'd3, 5'd1, 5'd2, 2'd1, 4'h2, 0, 5'd0, 0, 5'd0, "R6 waw over unit");
        drive(0, 5'd3, 5'd3, 5'd3, 2'd1, 4'hF, 0, 5'd0, 0, 5'd0, "R7 invalid ignored");
        drive(1, 5'd10, 5'd3, 5'd1, 2'd2, 4'h0, 0, 5'd0, 1, 5'd3, "R9 bypass on port1");
        idle("R8 r3 cleared, R4 r10 set");
        drive(1, 5'd0, 5'd0, 5'd0, 2'd2, 4'h0, 0, 5'd0, 0, 5'd0, "R10 rd zero grant");
        drive(1, 5'd12, 5'd0, 5'd0, 2'd3, 4'h0, 1, 5'd10, 0, 5'd0, "R8 port0 clear r10");
        drive(0, 5'd0, 5'd0, 5'd0, 2'd0, 4'h0, 1, 5'd12, 1, 5'd12, "R11 double clear r12");
        drive(1, 5'd12, 5'd1, 5'd2, 2'd0, 4'h0, 0, 5'd0, 0, 5'd0, "R11 reissue r12");
        drive(1, 5'd12, 5'd1, 5'd2, 2'd0, 4'h0, 1, 5'd12, 0, 5'd0, "R11 clear and grant same reg");
        idle("R11 r12 stays set, R10 r0 clear");
        // Mixed traffic: rotating registers, busy units and completions.
        for (int i = 0; i < 200; i++) begin
            drive(1'b1, 5'((i * 7) % 32), 5'((i * 3) % 32), 5'((i * 5 + 1) % 32),
                  2'(i % 4), 4'((i % 5 == 0) ? 4'h5 : 4'h0),
                  1'(i % 2), 5'((i * 7 + 25) % 32), 1'(i % 3 == 0), 5'((i * 3) % 32),
                  "R2 R3 R4 R5 R8 R9 mixed traffic");
        end
        idle("R8 final state");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule